// File: doc/BRIEF.md
# Masked Packed Arithmetic Right Shifter

This block is a SIMD datapath stage for a vector execution unit. It receives an already-fetched 256-bit source vector, the previous contents of the destination, a shift count and a set of control bits. It then treats the vector as packed signed elements of 16, 32 or 64 bits and shifts each element right. The bits vacated at the top of each element are filled with copies of that element's sign bit. The result is registered and appears one clock after the input strobe.

The shift amount comes either from an 8-bit unsigned immediate or from the low 64 bits of a 128-bit count vector. Any amount at or beyond the element width collapses each element to pure sign. A per-lane write mask selects which lanes take the shifted value. Lanes that are not selected either keep the old destination value or are cleared. A broadcast option feeds source element 0 into every lane. A length select cuts the result to 128 bits by clearing the upper half.

Top module: `simd_sar_unit`

## Requirements
- R1: With `elem_sel`=00 the vector is handled as sixteen 16-bit lanes (lane i = bits 16i+15:16i). Each lane is shifted right by the count, and the vacated high bits are copies of that lane's bit 15.
- R2: With `elem_sel`=01 the vector is handled as eight 32-bit lanes, each shifted arithmetically with sign fill from its own bit 31.
- R3: With `elem_sel`=10 the vector is handled as four 64-bit lanes, each shifted arithmetically with sign fill from its own bit 63.
- R4: A count greater than 15 (16-bit lanes), 31 (32-bit lanes) or 63 (64-bit lanes) turns every written lane into all copies of its sign bit.
- R5: When `imm_sel`=0 the count is `cnt_vec[63:0]`, taken as an unsigned 64-bit value. `cnt_vec[127:64]` has no effect. A set bit anywhere in `cnt_vec[63:8]` still counts toward saturation.
- R6: When `imm_sel`=1 the count is `imm_cnt` as an unsigned value from 0 to 255, and `cnt_vec` has no effect.
- R7: When `mask_on`=0 every lane is written. When `mask_on`=1 and `zero_mode`=0, a lane whose `lane_mask` bit is clear keeps the value from `prev_dst`. The mask bit for lane i is `lane_mask[i]`.
- R8: When `mask_on`=1 and `zero_mode`=1, a lane whose `lane_mask` bit is clear becomes zero.
- R9: When `bcast_en`=1, `imm_sel`=1 and the element size is 32 or 64 bits, every lane is computed from source element 0. For 16-bit lanes, or with a register count, `bcast_en` has no effect.
- R10: When `wide_sel`=0, result bits 255:128 are zero whatever the mask mode. When `wide_sel`=1 all 256 bits are produced.
- R11: `elem_sel`=11 is reserved. It yields an all-zero result, and `out_valid` is still raised.
- R12: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and is low after reset. `out_vec` holds its value while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands valid this cycle |
| src_vec | input | 256 | Packed source elements |
| prev_dst | input | 256 | Old destination value for merge masking |
| cnt_vec | input | 128 | Register count operand (low 64 bits used) |
| imm_cnt | input | 8 | Immediate count |
| imm_sel | input | 1 | 1 selects immediate count |
| elem_sel | input | 2 | 00 16-bit, 01 32-bit, 10 64-bit, 11 reserved |
| wide_sel | input | 1 | 1 for 256-bit result, 0 for 128-bit |
| mask_on | input | 1 | Enable per-lane write mask |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 merges |
| bcast_en | input | 1 | Broadcast element 0 (immediate count, 32/64-bit only) |
| lane_mask | input | 16 | One write-enable bit per lane |
| out_valid | output | 1 | Result valid |
| out_vec | output | 256 | Registered result |

## Verification
Broadcast and merge masking can meet on the same operation, and so can count saturation and the 128-bit length cut. In that case one lane carries the shifted copy of element 0, a neighbouring lane carries old destination data, and the upper half must be cleared on top of both. Directed cases set these together: broadcast with a sparse mask under merging, a saturating register count under zeroing, and a merge with `wide_sel`=0. A stream of mixed random operations back-to-back then mixes every control combination. Each result is judged against a bit-by-bit behavioural model that computes the expected lane values straight from the requirement rules.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Element size encoding on elem_sel
  typedef enum logic [1:0] {
    ES_W16 = 2'b00,
    ES_W32 = 2'b01,
    ES_W64 = 2'b10,
    ES_RSV = 2'b11
  } esize_e;

  localparam int CHUNK_W = 16;  // narrowest lane, mask granule
endpackage

// File: rtl/sar_count_unit.sv
// Derives per-size saturated shift amounts from the selected count source.
module sar_count_unit #(
  parameter int CW = 128,
  parameter int IW = 8
) (
  input  logic [CW-1:0] cnt_vec,
  input  logic [IW-1:0] imm_cnt,
  input  logic          imm_sel,
  output logic [3:0]    amt_w16,
  output logic [4:0]    amt_w32,
  output logic [5:0]    amt_w64
);
  logic [63:0] raw_cnt;
  logic        unused_cnt_hi;

  assign unused_cnt_hi = ^cnt_vec[CW-1:64];
  assign raw_cnt = imm_sel ? {{(64-IW){1'b0}}, imm_cnt} : cnt_vec[63:0];

  // Shifting by width-1 already yields pure sign, so clamp there.
  assign amt_w16 = (|raw_cnt[63:4]) ? 4'hF  : raw_cnt[3:0];
  assign amt_w32 = (|raw_cnt[63:5]) ? 5'h1F : raw_cnt[4:0];
  assign amt_w64 = (|raw_cnt[63:6]) ? 6'h3F : raw_cnt[5:0];

  always_comb begin
    assert_sat_w16_R4: assert (!(raw_cnt > 64'd15) || amt_w16 == 4'hF);
    assert_sat_w64_R4: assert (!(raw_cnt > 64'd63) || amt_w64 == 6'h3F);
    assert_imm_src_R6: assert (!(imm_sel === 1'b1) || raw_cnt < 64'd256);
  end
endmodule

// File: rtl/sar_lane_bank.sv
// One row of identical arithmetic shifters for a single element width.
module sar_lane_bank #(
  parameter int VEC_W = 256,
  parameter int EW    = 16,
  parameter int AW    = $clog2(EW)
) (
  input  logic [VEC_W-1:0] src,
  input  logic [AW-1:0]    amt,
  input  logic             bcast,
  output logic [VEC_W-1:0] res
);
  localparam int NLANE = VEC_W / EW;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [EW-1:0] elem;
    assign elem = bcast ? src[EW-1:0] : src[l*EW +: EW];
    assign res[l*EW +: EW] = $signed(elem) >>> amt;
  end
endmodule

// File: rtl/sar_mask_merge.sv
// Selects the lane bank, applies merge/zero masking and the length cut.
module sar_mask_merge
  import sar_pkg::*;
#(
  parameter int VEC_W = 256,
  parameter int NL    = VEC_W / CHUNK_W
) (
  input  logic [VEC_W-1:0] res_w16,
  input  logic [VEC_W-1:0] res_w32,
  input  logic [VEC_W-1:0] res_w64,
  input  logic [VEC_W-1:0] prev_dst,
  input  logic [1:0]       elem_sel,
  input  logic             wide_sel,
  input  logic             mask_on,
  input  logic             zero_mode,
  input  logic [NL-1:0]    lane_mask,
  output logic [VEC_W-1:0] merged
);
  localparam int NCHUNK = VEC_W / CHUNK_W;

  logic [NCHUNK-1:0] wen_w16, wen_w32, wen_w64, wen_sel;
  logic [VEC_W-1:0]  shifted;

  // Expand lane mask to chunk granularity for each element size
  for (genvar c = 0; c < NCHUNK; c++) begin : g_expand
    assign wen_w16[c] = lane_mask[c];
    assign wen_w32[c] = lane_mask[c/2];
    assign wen_w64[c] = lane_mask[c/4];
  end

  always_comb begin
    unique case (esize_e'(elem_sel))
      ES_W16:  begin shifted = res_w16; wen_sel = wen_w16; end
      ES_W32:  begin shifted = res_w32; wen_sel = wen_w32; end
      ES_W64:  begin shifted = res_w64; wen_sel = wen_w64; end
      default: begin shifted = '0;      wen_sel = '0;      end
    endcase
  end

  always_comb begin
    merged = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      if (!mask_on || wen_sel[c])
        merged[c*CHUNK_W +: CHUNK_W] = shifted[c*CHUNK_W +: CHUNK_W];
      else if (!zero_mode)
        merged[c*CHUNK_W +: CHUNK_W] = prev_dst[c*CHUNK_W +: CHUNK_W];
      if ((!wide_sel && c >= NCHUNK/2) || elem_sel == ES_RSV)
        merged[c*CHUNK_W +: CHUNK_W] = '0;
    end
  end
endmodule

// File: rtl/simd_sar_unit.sv
module simd_sar_unit
  import sar_pkg::*;
#(
  parameter int VEC_W = 256,
  parameter int CNT_W = 128,
  parameter int IMM_W = 8,
  localparam int NL   = VEC_W / CHUNK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] prev_dst,
  input  logic [CNT_W-1:0] cnt_vec,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic             imm_sel,
  input  logic [1:0]       elem_sel,
  input  logic             wide_sel,
  input  logic             mask_on,
  input  logic             zero_mode,
  input  logic             bcast_en,
  input  logic [NL-1:0]    lane_mask,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec
);
  logic [3:0]       amt_w16;
  logic [4:0]       amt_w32;
  logic [5:0]       amt_w64;
  logic             bcast_act;
  logic [VEC_W-1:0] res_w16, res_w32, res_w64, merged_vec;
  logic             valid_d, valid_q;
  logic [VEC_W-1:0] vec_d, vec_q;

  assign bcast_act = bcast_en & imm_sel;

  sar_count_unit #(.CW(CNT_W), .IW(IMM_W)) u_count (
    .cnt_vec (cnt_vec),
    .imm_cnt (imm_cnt),
    .imm_sel (imm_sel),
    .amt_w16 (amt_w16),
    .amt_w32 (amt_w32),
    .amt_w64 (amt_w64)
  );

  sar_lane_bank #(.VEC_W(VEC_W), .EW(16)) u_bank16 (
    .src (src_vec), .amt (amt_w16), .bcast (1'b0), .res (res_w16)
  );
  sar_lane_bank #(.VEC_W(VEC_W), .EW(32)) u_bank32 (
    .src (src_vec), .amt (amt_w32), .bcast (bcast_act), .res (res_w32)
  );
  sar_lane_bank #(.VEC_W(VEC_W), .EW(64)) u_bank64 (
    .src (src_vec), .amt (amt_w64), .bcast (bcast_act), .res (res_w64)
  );

  sar_mask_merge #(.VEC_W(VEC_W)) u_merge (
    .res_w16   (res_w16),
    .res_w32   (res_w32),
    .res_w64   (res_w64),
    .prev_dst  (prev_dst),
    .elem_sel  (elem_sel),
    .wide_sel  (wide_sel),
    .mask_on   (mask_on),
    .zero_mode (zero_mode),
    .lane_mask (lane_mask),
    .merged    (merged_vec)
  );

  // Next-state
  always_comb begin
    valid_d = in_valid;
    vec_d   = in_valid ? merged_vec : vec_q;
  end

  // Registers: only the valid flag is reset; data is clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) vec_q <= vec_d;
  end

  assign out_valid = valid_q;
  assign out_vec   = vec_q;

  assert_valid_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> $stable(out_vec));
  assert_upper_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel) |=> (out_vec[VEC_W-1:VEC_W/2] == '0));
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sel == ES_RSV) |=> (out_valid && out_vec == '0));
  assert_zeroing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_on && zero_mode && lane_mask == '0) |=> (out_vec == '0));
  assert_merge_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_on && !zero_mode && lane_mask == '0 && wide_sel &&
     elem_sel != ES_RSV) |=> (out_vec == $past(prev_dst)));
endmodule

// File: tb/simd_sar_unit_tb.sv
`timescale 1ns/1ps
module simd_sar_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [255:0] src_vec, prev_dst;
  logic [127:0] cnt_vec;
  logic [7:0]   imm_cnt;
  logic         imm_sel, wide_sel, mask_on, zero_mode, bcast_en;
  logic [1:0]   elem_sel;
  logic [15:0]  lane_mask;
  logic         out_valid;
  logic [255:0] out_vec;

  int n_checks = 0;
  int n_fails  = 0;
  logic [255:0] last_exp;
  bit done = 0;

  always #2 clk = ~clk;

  simd_sar_unit u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .src_vec (src_vec), .prev_dst (prev_dst), .cnt_vec (cnt_vec),
    .imm_cnt (imm_cnt), .imm_sel (imm_sel), .elem_sel (elem_sel),
    .wide_sel (wide_sel), .mask_on (mask_on), .zero_mode (zero_mode),
    .bcast_en (bcast_en), .lane_mask (lane_mask),
    .out_valid (out_valid), .out_vec (out_vec)
  );

  // Behavioural reference, bit by bit from the requirement rules
  function automatic logic [255:0] ref_model(
    input logic [255:0] s, input logic [255:0] p, input logic [127:0] cv,
    input logic [7:0] im, input logic isel, input logic [1:0] es,
    input logic wide, input logic mon, input logic zm, input logic bc,
    input logic [15:0] km);
    logic [255:0] r;
    logic [63:0]  cnt, e, sh;
    int ew, nl;
    logic sg, take, use_b;
    r = '0;
    if (es == 2'b11) return r;
    ew = (es == 2'b00) ? 16 : (es == 2'b01) ? 32 : 64;
    nl = 256 / ew;
    cnt = isel ? {56'd0, im} : cv[63:0];
    use_b = bc && isel && (es != 2'b00);
    for (int l = 0; l < nl; l++) begin
      e = '0; sh = '0;
      for (int b = 0; b < ew; b++) e[b] = use_b ? s[b] : s[l*ew+b];
      sg = e[ew-1];
      for (int b = 0; b < ew; b++)
        sh[b] = (cnt < 64'(ew - b)) ? e[b + int'(cnt[6:0])] : sg;
      take = !mon || km[l];
      for (int b = 0; b < ew; b++)
        r[l*ew+b] = take ? sh[b] : (zm ? 1'b0 : p[l*ew+b]);
    end
    if (!wide) r[255:128] = '0;
    return r;
  endfunction

  task automatic issue(input string tag, input logic [255:0] s,
    input logic [255:0] p, input logic [127:0] cv, input logic [7:0] im,
    input logic isel, input logic [1:0] es, input logic wide,
    input logic mon, input logic zm, input logic bc, input logic [15:0] km);
    logic [255:0] exp_v;
    @(negedge clk);
    in_valid = 1'b1; src_vec = s; prev_dst = p; cnt_vec = cv; imm_cnt = im;
    imm_sel = isel; elem_sel = es; wide_sel = wide; mask_on = mon;
    zero_mode = zm; bcast_en = bc; lane_mask = km;
    exp_v = ref_model(s, p, cv, im, isel, es, wide, mon, zm, bc, km);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b1 || out_vec !== exp_v) begin
      n_fails++;
      $display("FAIL %s: valid=%b vec=%h expected valid=1 vec=%h",
               tag, out_valid, out_vec, exp_v);
    end
    last_exp = exp_v;
  endtask

  // R12: idle cycle, valid drops and data holds even if operands move
  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    src_vec = ~src_vec; prev_dst = ~prev_dst; imm_cnt = imm_cnt + 8'd3;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_vec !== last_exp) begin
      n_fails++;
      $display("FAIL R12 idle: valid=%b vec=%h expected valid=0 vec=%h",
               out_valid, out_vec, last_exp);
    end
  endtask

  localparam logic [255:0] PAT_A =
    256'h8001_7FFF_F0F0_0F0F_8000_0001_FFFF_1234_C3C3_3C3C_9ABC_5678_A5A5_5A5A_FF00_00FF;
  localparam logic [255:0] PAT_B =
    256'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_CAFE_F00D_8BAD_F00D_1357_9BDF;
  localparam logic [255:0] OLD_D =
    256'h1111_2222_3333_4444_5555_6666_7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE_0F1E_2D3C;

  initial begin
    #200000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; prev_dst = '0; cnt_vec = '0;
    imm_cnt = '0; imm_sel = 1'b0; elem_sel = 2'b00; wide_sel = 1'b1;
    mask_on = 1'b0; zero_mode = 1'b0; bcast_en = 1'b0; lane_mask = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 reset: valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;

    issue("R1 w16 by 3",    PAT_A, OLD_D, 128'd3,  8'd0,  0, 2'b00, 1, 0, 0, 0, 16'h0000);
    issue("R2 w32 by 7",    PAT_B, OLD_D, 128'd0,  8'd7,  1, 2'b01, 1, 0, 0, 0, 16'h0000);
    issue("R3 w64 by 40",   PAT_B, OLD_D, 128'd40, 8'd0,  0, 2'b10, 1, 0, 0, 0, 16'h0000);
    issue("R4 w16 by 16",   PAT_A, OLD_D, 128'd0,  8'd16, 1, 2'b00, 1, 0, 0, 0, 16'h0000);
    issue("R4 w32 by 200",  PAT_B, OLD_D, 128'd0,  8'd200,1, 2'b01, 1, 0, 0, 0, 16'h0000);
    issue("R4 w64 by 63",   PAT_B, OLD_D, 128'd63, 8'd0,  0, 2'b10, 1, 0, 0, 0, 16'h0000);
    issue("R5 hi half ignored", PAT_A, OLD_D, {64'hFFFF_FFFF_FFFF_FFFF, 64'd5},
          8'd0, 0, 2'b00, 1, 0, 0, 0, 16'h0000);
    issue("R5 bit40 saturates", PAT_B, OLD_D, {64'd0, 64'h0000_0100_0000_0001},
          8'd0, 0, 2'b01, 1, 0, 0, 0, 16'h0000);
    issue("R6 imm ignores cnt_vec", PAT_A, OLD_D, {128{1'b1}}, 8'd2,
          1, 2'b00, 1, 0, 0, 0, 16'h0000);
    idle_check();
    issue("R7 mask off",    PAT_A, OLD_D, 128'd1,  8'd0,  0, 2'b00, 1, 0, 1, 0, 16'h0000);
    issue("R7 merge",       PAT_A, OLD_D, 128'd4,  8'd0,  0, 2'b00, 1, 1, 0, 0, 16'hA5C3);
    issue("R8 zeroing",     PAT_B, OLD_D, 128'd0,  8'd9,  1, 2'b01, 1, 1, 1, 0, 16'h0096);
    issue("R8 zero sat",    PAT_B, OLD_D, 128'd99, 8'd0,  0, 2'b10, 1, 1, 1, 0, 16'h0005);
    issue("R9 bcast w32 merge", PAT_B, OLD_D, 128'd0, 8'd5, 1, 2'b01, 1, 1, 0, 1, 16'h0035);
    issue("R9 bcast w64",   PAT_A, OLD_D, 128'd0,  8'd12, 1, 2'b10, 1, 0, 0, 1, 16'h0000);
    issue("R9 bcast w16 ignored", PAT_A, OLD_D, 128'd0, 8'd1, 1, 2'b00, 1, 0, 0, 1, 16'h0000);
    issue("R9 bcast reg ignored", PAT_B, OLD_D, 128'd3, 8'd0, 0, 2'b01, 1, 0, 0, 1, 16'h0000);
    issue("R10 len128 merge", PAT_A, OLD_D, 128'd2, 8'd0, 0, 2'b00, 0, 1, 0, 0, 16'h0F0F);
    issue("R10 len128 plain", PAT_B, OLD_D, 128'd0, 8'd33, 1, 2'b10, 0, 0, 0, 0, 16'h0000);
    issue("R11 reserved",   PAT_A, OLD_D, 128'd1,  8'd0,  0, 2'b11, 1, 1, 0, 0, 16'h0000);
    idle_check();

    for (int i = 0; i < 300; i++) begin
      logic [255:0] rs, rp;
      logic [127:0] rc;
      logic [7:0]   ri;
      for (int w = 0; w < 8; w++) begin
        rs[w*32 +: 32] = $urandom;
        rp[w*32 +: 32] = $urandom;
      end
      rc = {$urandom, $urandom, 32'd0, 32'($urandom % 70)};
      if ($urandom % 8 == 0) rc[63:32] = $urandom;
      ri = 8'($urandom);
      issue("R1 R2 R3 R7 R9 random", rs, rp, rc, ri, 1'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
      if (i % 37 == 0) idle_check();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule